// File: doc/BRIEF.md
# Nine-Bit Two-Phase Stored-Program Processor

This block is a very small processor. Its instructions and its data words are both 9 bits wide. It has four general registers and a 16-word memory that holds both program and data. Each instruction takes two clock cycles. In the FETCH state, the block reads the word addressed by the program counter into the instruction register and advances the counter. In the EXEC state, it decodes a 3-bit opcode and performs one operation. A self-jump is recognised as the end of the program: the block then moves into the HALT state and stays there until reset.

Software places a program in memory through the load port while reset is held. Reset does not clear memory, so the same image can be run again. Two memory addresses are given over to I/O. Reading address 14 returns the input port, and writing address 15 drives the output port. The Read and Write opcodes reach those same ports directly.

State transitions:
- FETCH goes to EXEC on every clock.
- EXEC goes to FETCH, except when a jump targets its own address; that case goes to HALT.
- HALT stays in HALT.
- Reset forces FETCH from any state.

Top module: `cpu9_core`

## Requirements
- R1: Synchronous reset clears the program counter, the instruction register, all four registers and the output port (data and strobe) and enters FETCH. Execution then starts at address 0.
- R2: Every instruction that does not halt takes exactly two cycles, FETCH then EXEC, and each FETCH adds one to the program counter (modulo 16).
- R3: The opcode is bits [8:6]. Sub (000) writes source1 minus source2 to the destination, and Add (001) writes source1 plus source2, both modulo 512. The destination is bits [5:4], source1 is bits [3:2] and source2 is bits [1:0].
- R4: Load (010) copies memory word [3:0] into register [5:4]. Store (011) writes register [5:4] to memory word [3:0], where it stays.
- R5: Read (100) copies the input port into register [5:4]. A Load from address 14 also returns the input port.
- R6: Write (101) puts register [5:4] on the output port with a one-cycle valid strobe. A Store to address 15 does the same with the stored value.
- R7: GoTo (110) loads the program counter with field [3:0].
- R8: BranchIf (111) loads the program counter with field [3:0] only when register [5:4] is zero. Otherwise execution continues with the next word.
- R9: A GoTo whose target equals its own address raises `halted`. After that there are no further strobes, and `halted` stays high until reset.
- R10: Load-port writes are accepted while reset is held, and reset leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Program-load write enable |
| ld_addr | input | 4 | Program-load word address |
| ld_data | input | 9 | Program-load word |
| in_port | input | 9 | Input port value (address 14) |
| out_data | output | 9 | Output port value (address 15) |
| out_valid | output | 1 | One-cycle strobe when a new value is put on the output port |
| halted | output | 1 | High once a self-jump has executed |

## Verification
Two things happen in the same cycle: loading the program through the load port, and reset clearing the registers. Every run loads its image while reset is held. The bench then re-runs a program without reloading it and compares the output port value and the number of cycles to halt with the first run. A second run that starts with a Write of a register the previous program left non-zero must output zero. That result shows that reset clears the registers but leaves the loaded memory intact.

// File: rtl/cpu9_pkg.sv
package cpu9_pkg;

    localparam int OP_W = 3;

    typedef enum logic [2:0] {
        OP_SUB   = 3'b000,
        OP_ADD   = 3'b001,
        OP_LOAD  = 3'b010,
        OP_STORE = 3'b011,
        OP_READ  = 3'b100,
        OP_WRITE = 3'b101,
        OP_GOTO  = 3'b110,
        OP_BRZ   = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } state_e;

endpackage

// File: rtl/cpu9_regs.sv
module cpu9_regs #(
    parameter int REG_AW = 2,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    input  logic [REG_AW-1:0] ra_d,
    output logic [WORD_W-1:0] rd_a,
    output logic [WORD_W-1:0] rd_b,
    output logic [WORD_W-1:0] rd_d
);
    localparam int NREGS = 1 << REG_AW;

    logic [WORD_W-1:0] r_q [NREGS];
    logic [NREGS-1:0]  zero_v;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) begin
                r_q[i] <= '0;
            end else if (we && waddr == REG_AW'(i)) begin
                r_q[i] <= wdata;
            end
        end
    end

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_zero
            assign zero_v[g] = (r_q[g] == '0);
        end
    endgenerate

    assign rd_a = r_q[ra_a];
    assign rd_b = r_q[ra_b];
    assign rd_d = r_q[ra_d];

    // R1
    regs_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&zero_v));

endmodule

// File: rtl/cpu9_memio.sv
module cpu9_memio #(
    parameter int MEM_AW = 4,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [MEM_AW-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              port_we,
    input  logic [WORD_W-1:0] port_wdata,
    input  logic [WORD_W-1:0] in_port,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam logic [MEM_AW-1:0] IN_ADDR  = MEM_AW'(DEPTH - 2);
    localparam logic [MEM_AW-1:0] OUT_ADDR = MEM_AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] out_q;
    logic              valid_q;
    logic              store_out;

    assign store_out = we && (addr == OUT_ADDR);

    // memory is not reset: the image loaded under reset survives it
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem_q[ld_addr] <= ld_data;
        end else if (we && addr < IN_ADDR) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = (addr == IN_ADDR) ? in_port : mem_q[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= port_we || store_out;
            if (port_we) begin
                out_q <= port_wdata;
            end else if (store_out) begin
                out_q <= wdata;
            end
        end
    end

    assign out_data  = out_q;
    assign out_valid = valid_q;

    // R6
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!port_we && !store_out) |=> $stable(out_q));

endmodule

// File: rtl/cpu9_ctrl.sv
module cpu9_ctrl
    import cpu9_pkg::*;
#(
    parameter int REG_AW = 2,
    parameter int WORD_W = OP_W + 3 * REG_AW,
    parameter int MEM_AW = 2 * REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] rf_a,
    input  logic [WORD_W-1:0] rf_b,
    input  logic [WORD_W-1:0] rf_d,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              port_we,
    output logic [WORD_W-1:0] port_wdata,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [REG_AW-1:0] ra_a,
    output logic [REG_AW-1:0] ra_b,
    output logic [REG_AW-1:0] ra_d,
    output logic              halted
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam logic [MEM_AW-1:0] IN_ADDR = MEM_AW'(DEPTH - 2);

    state_e            state_q, state_d;
    logic [MEM_AW-1:0] pc_q, pc_d;
    logic [MEM_AW-1:0] cur_q;
    logic [WORD_W-1:0] ir_q;

    opcode_e           op;
    logic [REG_AW-1:0] f_dst, f_s1, f_s2;
    logic [MEM_AW-1:0] f_addr;

    assign op     = opcode_e'(ir_q[WORD_W-1 -: OP_W]);
    assign f_dst  = ir_q[3*REG_AW-1 -: REG_AW];
    assign f_s1   = ir_q[2*REG_AW-1 -: REG_AW];
    assign f_s2   = ir_q[REG_AW-1:0];
    assign f_addr = ir_q[MEM_AW-1:0];

    // state register and sequential context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            cur_q   <= '0;
            ir_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (state_q == ST_FETCH) begin
                ir_q  <= mem_rdata;
                cur_q <= pc_q;
            end
        end
    end

    // next state and program counter
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_FETCH: begin
                state_d = ST_EXEC;
                pc_d    = pc_q + 1'b1;
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                if (op == OP_GOTO) begin
                    pc_d = f_addr;
                    if (f_addr == cur_q) begin
                        state_d = ST_HALT;
                    end
                end else if (op == OP_BRZ && rf_d == '0) begin
                    pc_d = f_addr;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    // datapath controls
    always_comb begin
        mem_addr   = pc_q;
        mem_we     = 1'b0;
        mem_wdata  = rf_d;
        port_we    = 1'b0;
        port_wdata = rf_d;
        rf_we      = 1'b0;
        rf_wdata   = '0;
        if (state_q == ST_EXEC) begin
            mem_addr = f_addr;
            unique case (op)
                OP_SUB: begin
                    rf_we    = 1'b1;
                    rf_wdata = rf_a - rf_b;
                end
                OP_ADD: begin
                    rf_we    = 1'b1;
                    rf_wdata = rf_a + rf_b;
                end
                OP_LOAD: begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                end
                OP_STORE: begin
                    mem_we = 1'b1;
                end
                OP_READ: begin
                    mem_addr = IN_ADDR;
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                end
                OP_WRITE: begin
                    port_we = 1'b1;
                end
                OP_GOTO, OP_BRZ: begin
                    rf_we = 1'b0;
                end
                default: begin
                    rf_we = 1'b0;
                end
            endcase
        end
    end

    assign rf_waddr = f_dst;
    assign ra_a     = f_s1;
    assign ra_b     = f_s2;
    assign ra_d     = f_dst;
    assign halted   = (state_q == ST_HALT);

    // R1
    reset_start_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && state_q == ST_FETCH && ir_q == '0));

    // R2
    fetch_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + 1'b1 && state_q == ST_EXEC));

    // R2
    exec_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC) |=> (state_q != ST_EXEC));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT && $stable(pc_q)));

    // R7
    goto_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && op == OP_GOTO) |=> (pc_q == $past(f_addr)));

endmodule

// File: rtl/cpu9_core.sv
module cpu9_core #(
    parameter int REG_AW = 2,
    parameter int WORD_W = cpu9_pkg::OP_W + 3 * REG_AW,
    parameter int MEM_AW = 2 * REG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [WORD_W-1:0] in_port,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic              port_we;
    logic [WORD_W-1:0] port_wdata;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr, ra_a, ra_b, ra_d;
    logic [WORD_W-1:0] rf_wdata, rf_a, rf_b, rf_d;

    cpu9_ctrl #(.REG_AW(REG_AW), .WORD_W(WORD_W), .MEM_AW(MEM_AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .mem_rdata(mem_rdata), .rf_a(rf_a), .rf_b(rf_b), .rf_d(rf_d),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .port_we(port_we), .port_wdata(port_wdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .ra_a(ra_a), .ra_b(ra_b), .ra_d(ra_d),
        .halted(halted)
    );

    cpu9_regs #(.REG_AW(REG_AW), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst(rst),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .ra_a(ra_a), .ra_b(ra_b), .ra_d(ra_d),
        .rd_a(rf_a), .rd_b(rf_b), .rd_d(rf_d)
    );

    cpu9_memio #(.MEM_AW(MEM_AW), .WORD_W(WORD_W)) u_mem (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .addr(mem_addr), .we(mem_we), .wdata(mem_wdata),
        .port_we(port_we), .port_wdata(port_wdata),
        .in_port(in_port), .rdata(mem_rdata),
        .out_data(out_data), .out_valid(out_valid)
    );

    // R9
    no_strobe_halted_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> !out_valid);

endmodule

// File: tb/sim_cpu9_core.sv
module sim_cpu9_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [8:0] ld_data = '0;
    logic [8:0] in_port = '0;
    logic [8:0] out_data;
    logic       out_valid;
    logic       halted;

    always #4 clk = ~clk;

    cpu9_core u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_port(in_port), .out_data(out_data), .out_valid(out_valid), .halted(halted)
    );

    int         checks = 0;
    int         fails = 0;
    int         strobes;
    logic [8:0] first_out;
    logic [8:0] last_out;
    logic [8:0] prog [16];

    // opcodes: SUB 000 ADD 001 LOAD 010 STORE 011 READ 100 WRITE 101 GOTO 110 BRZ 111
    // vector: {is_add, a, b, expected}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 9'd7,   9'd5,   9'd2},
        {1'b1, 9'd3,   9'd4,   9'd7},
        {1'b1, 9'd511, 9'd1,   9'd0},
        {1'b0, 9'd0,   9'd1,   9'd511},
        {1'b1, 9'd256, 9'd300, 9'd44},
        {1'b0, 9'd100, 9'd100, 9'd0},
        {1'b1, 9'd0,   9'd0,   9'd0},
        {1'b0, 9'd300, 9'd45,  9'd255}
    };

    always @(negedge clk) begin
        if (rst) begin
            strobes   <= 0;
            first_out <= '0;
            last_out  <= '0;
        end else if (out_valid) begin
            strobes  <= strobes + 1;
            last_out <= out_data;
            if (strobes == 0) first_out <= out_data;
        end
    end

    function automatic logic [8:0] mi(input logic [2:0] op, input logic [1:0] rd, input logic [3:0] f);
        return {op, rd, f};
    endfunction

    function automatic logic [8:0] ri(input logic [2:0] op, input logic [1:0] rd,
                                       input logic [1:0] s1, input logic [1:0] s2);
        return {op, rd, s1, s2};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = '0;
    endtask

    task automatic run(input bit reload, output int cyc);
        @(negedge clk);
        rst = 1'b1;
        if (reload) begin
            for (int i = 0; i < 16; i++) begin
                ld_en = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
                @(negedge clk);
            end
            ld_en = 1'b0;
        end else begin
            @(negedge clk);
        end
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        #1;
        if (cyc >= 500) chk("R9 halt reached", 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        int cyc_first;
        repeat (3) @(negedge clk);
        #1;
        // R1: state under reset
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 halted in reset", int'(halted), 0);
        chk("R1 out_data in reset", int'(out_data), 0);

        // R3 R4: vector table through Load/op/Store/Load/Write
        for (int v = 0; v < 8; v++) begin
            clear_prog();
            prog[0]  = mi(3'b010, 2'd1, 4'd8);
            prog[1]  = mi(3'b010, 2'd2, 4'd9);
            prog[2]  = ri({2'b00, VEC[v][27]}, 2'd3, 2'd1, 2'd2);
            prog[3]  = mi(3'b011, 2'd3, 4'd10);
            prog[4]  = mi(3'b010, 2'd0, 4'd10);
            prog[5]  = mi(3'b101, 2'd0, 4'd0);
            prog[6]  = mi(3'b110, 2'd0, 4'd6);
            prog[8]  = VEC[v][26:18];
            prog[9]  = VEC[v][17:9];
            run(1'b1, cyc);
            chk($sformatf("R3 R4 vector %0d result", v), int'(last_out), int'(VEC[v][8:0]));
            chk($sformatf("R6 vector %0d strobe count", v), strobes, 1);
        end

        // R1: registers cleared by reset (R0 held non-zero before)
        clear_prog();
        prog[0] = mi(3'b101, 2'd0, 4'd0);
        prog[1] = mi(3'b110, 2'd0, 4'd1);
        run(1'b1, cyc);
        chk("R1 register cleared by reset", int'(last_out), 0);
        chk("R1 first instruction at address 0", strobes, 1);

        // R3 R4 R5 R6 R2: worked example with input port 7
        clear_prog();
        in_port  = 9'd7;
        prog[0]  = mi(3'b010, 2'd2, 4'd12);
        prog[1]  = mi(3'b100, 2'd3, 4'd14);
        prog[2]  = ri(3'b000, 2'd1, 2'd3, 2'd2);
        prog[3]  = mi(3'b011, 2'd1, 4'd13);
        prog[4]  = mi(3'b010, 2'd0, 4'd13);
        prog[5]  = mi(3'b101, 2'd1, 4'd0);
        prog[6]  = mi(3'b101, 2'd0, 4'd0);
        prog[7]  = mi(3'b110, 2'd0, 4'd7);
        prog[12] = 9'd5;
        run(1'b1, cyc);
        cyc_first = cyc;
        chk("R5 R3 register R1 after Read/Sub", int'(first_out), 2);
        chk("R4 memory word 13 after Store", int'(last_out), 2);
        chk("R6 two strobes", strobes, 2);
        chk("R2 cycles to halt (8 instructions)", cyc, 16);

        // R9: halted holds, no further strobes
        repeat (12) @(negedge clk);
        #1;
        chk("R9 halted stays", int'(halted), 1);
        chk("R9 no strobes after halt", strobes, 2);

        // R10: rerun without reloading
        run(1'b0, cyc);
        chk("R10 rerun output", int'(last_out), 2);
        chk("R10 rerun cycle count", cyc, cyc_first);

        // R8: branch taken and not taken
        for (int t = 0; t < 2; t++) begin
            clear_prog();
            prog[0]  = mi(3'b010, 2'd1, 4'd12);
            prog[1]  = mi(3'b111, 2'd1, 4'd5);
            prog[2]  = mi(3'b010, 2'd3, 4'd13);
            prog[3]  = mi(3'b101, 2'd3, 4'd0);
            prog[4]  = mi(3'b110, 2'd0, 4'd4);
            prog[5]  = mi(3'b010, 2'd3, 4'd11);
            prog[6]  = mi(3'b101, 2'd3, 4'd0);
            prog[7]  = mi(3'b110, 2'd0, 4'd7);
            prog[11] = 9'd170;
            prog[12] = (t == 0) ? 9'd0 : 9'd1;
            prog[13] = 9'd85;
            run(1'b1, cyc);
            chk(t == 0 ? "R8 branch taken on zero" : "R8 fall through on non-zero",
                int'(last_out), t == 0 ? 170 : 85);
            chk("R8 one strobe", strobes, 1);
        end

        // R7: forward GoTo skips words
        clear_prog();
        prog[0]  = mi(3'b110, 2'd0, 4'd3);
        prog[1]  = mi(3'b010, 2'd1, 4'd11);
        prog[2]  = mi(3'b101, 2'd1, 4'd0);
        prog[3]  = mi(3'b010, 2'd2, 4'd13);
        prog[4]  = mi(3'b101, 2'd2, 4'd0);
        prog[5]  = mi(3'b110, 2'd0, 4'd5);
        prog[11] = 9'd170;
        prog[13] = 9'd85;
        run(1'b1, cyc);
        chk("R7 GoTo target output", int'(last_out), 85);
        chk("R7 skipped words give no strobe", strobes, 1);

        // R5 R6: Load from 14 and Store to 15
        clear_prog();
        in_port = 9'h123;
        prog[0] = mi(3'b010, 2'd2, 4'd14);
        prog[1] = mi(3'b011, 2'd2, 4'd15);
        prog[2] = mi(3'b110, 2'd0, 4'd2);
        run(1'b1, cyc);
        chk("R5 R6 input via Load 14, output via Store 15", int'(last_out), 'h123);
        chk("R6 store strobe count", strobes, 1);

        // R1: reset clears output port
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 out_data after reset", int'(out_data), 0);
        chk("R1 halted after reset", int'(halted), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule